// File: doc/BRIEF.md
# Cascaded Sample Counter

This block counts conversion pulses and flags the end of an acquisition once a programmed number of samples has been taken. It is built from two down-counters, each `HALF_W` bits wide. A host-side sequencer applies a single `2*HALF_W`-bit sample count on the load port. The block then works out the preset values for both halves, including the borrow correction. A later arm command starts counting.

In wide mode the low half counts every accepted pulse and wraps modulo 2^HALF_W. The high half steps down once each time the low half arrives at zero. The acquisition ends on the pulse that is accepted while both halves already sit at zero. In narrow mode only the low half takes part, and the high half holds its preset value. The mode is captured together with the count. The end flag is registered and sticky, and it freezes the counters until the next load or arm.

Top module: `sample_cascade_counter`

## Requirements
- R1: On a load, `lo_o` becomes (count[15:0] - 1) modulo 2^16 in the next cycle, so a low word of 0x0000 presets to 0xFFFF.
- R2: On a load, `hi_o` becomes count[31:16] unchanged when count[15:0] is 0x0000 or 0x0001, and count[31:16] + 1 (modulo 2^16) otherwise.
- R3: Each accepted pulse lowers `lo_o` by one, and a pulse accepted at zero (when not finishing) wraps `lo_o` to 0xFFFF.
- R4: In wide mode `hi_o` drops by one on the accepted pulse that takes `lo_o` from 1 to 0, and on no other pulse. In particular it does not drop on the wrap pulse.
- R5: In wide mode (`wide_i`=1 at load), with count N = H*65536 + L and N >= 1, `done_o` rises in the cycle after the N-th accepted pulse and not before.
- R6: In narrow mode (`wide_i`=0 at load), with low word L in 1..65535, `done_o` rises after the L-th accepted pulse, and `hi_o` keeps its preset value.
- R7: Once `done_o` is high it stays high, and further pulses leave `lo_o` and `hi_o` unchanged until a load or an arm. An arm clears `done_o`.
- R8: An arm before any load since reset is ignored. Pulses while `armed_o` is low change nothing.
- R9: A load clears `done_o` and `armed_o`, and it takes priority over an arm or a pulse in the same cycle.
- R10: A synchronous reset clears `lo_o`, `hi_o`, `done_o` and `armed_o`, and it forgets any earlier load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe: take `count_i` and `wide_i` |
| count_i | input | 2*HALF_W | Requested sample count |
| wide_i | input | 1 | 1 = both halves in use, 0 = low half only |
| arm_i | input | 1 | Start counting (after a load) |
| pulse_i | input | 1 | One conversion pulse per high cycle |
| armed_o | output | 1 | Counting enabled |
| done_o | output | 1 | Sticky end-of-acquisition flag |
| lo_o | output | HALF_W | Low counter value |
| hi_o | output | HALF_W | High counter value |

## Verification
The assertions assume that `pulse_i`, `load_i` and `arm_i` are clean one-cycle-per-event levels sampled on the clock edge. They also assume that load takes priority over every other strobe, so step properties are only claimed in cycles with no load or arm. The stimulus changes every input on the falling edge. It issues load and arm as single-cycle strobes, and it applies pulses either back to back or with random idle gaps. The one cycle that raises load, arm and pulse together is aimed at the priority requirement. Random counts keep full-length runs within a small high word, and the random loads probe the preset logic across the full 32-bit range.

// File: rtl/sample_cascade_pkg.sv
package sample_cascade_pkg;
   typedef enum logic {
      MODE_NARROW = 1'b0,
      MODE_WIDE   = 1'b1
   } cnt_mode_e;
endpackage

// File: rtl/scnt_preset.sv
module scnt_preset #(
   parameter int HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] count_i,
   output logic [HALF_W-1:0]   lo_pre_o,
   output logic [HALF_W-1:0]   hi_pre_o
);
   localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

   logic [HALF_W-1:0] low_word;
   logic [HALF_W-1:0] high_word;
   logic              borrow_fix;

   always_comb begin
      low_word   = count_i[HALF_W-1:0];
      high_word  = count_i[2*HALF_W-1:HALF_W];
      borrow_fix = (low_word > ONE);
      lo_pre_o   = low_word - ONE;
      hi_pre_o   = borrow_fix ? (high_word + ONE) : high_word;
   end
endmodule

// File: rtl/scnt_half.sv
module scnt_half #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         dec_i,
   output logic [W-1:0] val_o,
   output logic         zero_o
);
   localparam logic [W-1:0] STEP = W'(1);

   logic [W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (rst)
         val_q <= '0;
      else if (ld_i)
         val_q <= ld_val_i;
      else if (dec_i)
         val_q <= val_q - STEP;
   end

   assign val_o  = val_q;
   assign zero_o = (val_q == '0);
endmodule

// File: rtl/scnt_ctrl.sv
module scnt_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic load_i,
   input  logic arm_i,
   input  logic finish_i,
   output logic armed_o,
   output logic done_o
);
   logic loaded_q;
   logic armed_q;
   logic done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         loaded_q <= 1'b0;
         armed_q  <= 1'b0;
         done_q   <= 1'b0;
      end else if (load_i) begin
         loaded_q <= 1'b1;
         armed_q  <= 1'b0;
         done_q   <= 1'b0;
      end else if (arm_i && loaded_q) begin
         armed_q  <= 1'b1;
         done_q   <= 1'b0;
      end else if (finish_i) begin
         armed_q  <= 1'b0;
         done_q   <= 1'b1;
      end
   end

   assign armed_o = armed_q;
   assign done_o  = done_q;
endmodule

// File: rtl/sample_cascade_counter.sv
module sample_cascade_counter
   import sample_cascade_pkg::*;
#(
   parameter int HALF_W     = 16,
   parameter bit CASCADE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load_i,
   input  logic [2*HALF_W-1:0] count_i,
   input  logic                wide_i,
   input  logic                arm_i,
   input  logic                pulse_i,
   output logic                armed_o,
   output logic                done_o,
   output logic [HALF_W-1:0]   lo_o,
   output logic [HALF_W-1:0]   hi_o
);
   localparam logic [HALF_W-1:0] LAST_STEP = HALF_W'(1);

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("sample_cascade_counter: HALF_W must be at least 2");
      end
   endgenerate

   cnt_mode_e         mode_q;
   logic              wide_q;
   logic [HALF_W-1:0] lo_pre;
   logic [HALF_W-1:0] hi_pre;
   logic [HALF_W-1:0] lo_val;
   logic [HALF_W-1:0] hi_val;
   logic              lo_zero;
   logic              hi_zero;
   logic              accept;
   logic              finish;
   logic              lo_dec;
   logic              hi_dec;

   always_ff @(posedge clk) begin
      if (rst)
         mode_q <= MODE_NARROW;
      else if (load_i)
         mode_q <= (wide_i && CASCADE_EN) ? MODE_WIDE : MODE_NARROW;
   end
   assign wide_q = (mode_q == MODE_WIDE);

   scnt_preset #(.HALF_W(HALF_W)) preset_i (
      .count_i  (count_i),
      .lo_pre_o (lo_pre),
      .hi_pre_o (hi_pre)
   );

   always_comb begin
      accept = pulse_i && armed_o && !done_o && !load_i;
      finish = accept && lo_zero && (!wide_q || hi_zero);
      lo_dec = accept && !finish;
      hi_dec = lo_dec && wide_q && (lo_val == LAST_STEP);
   end

   scnt_half #(.W(HALF_W)) lo_cnt_i (
      .clk      (clk),
      .rst      (rst),
      .ld_i     (load_i),
      .ld_val_i (lo_pre),
      .dec_i    (lo_dec),
      .val_o    (lo_val),
      .zero_o   (lo_zero)
   );

   generate
      if (CASCADE_EN) begin : g_hi
         scnt_half #(.W(HALF_W)) hi_cnt_i (
            .clk      (clk),
            .rst      (rst),
            .ld_i     (load_i),
            .ld_val_i (hi_pre),
            .dec_i    (hi_dec),
            .val_o    (hi_val),
            .zero_o   (hi_zero)
         );
      end else begin : g_no_hi
         logic unused_hi;
         assign unused_hi = ^{hi_pre, hi_dec};
         assign hi_val    = '0;
         assign hi_zero   = 1'b1;
      end
   endgenerate

   scnt_ctrl ctrl_i (
      .clk      (clk),
      .rst      (rst),
      .load_i   (load_i),
      .arm_i    (arm_i),
      .finish_i (finish),
      .armed_o  (armed_o),
      .done_o   (done_o)
   );

   assign lo_o = lo_val;
   assign hi_o = hi_val;
endmodule

// File: rtl/sample_cascade_counter_chk.sv
module sample_cascade_counter_chk #(
   parameter int HALF_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              load_i,
   input logic              arm_i,
   input logic              pulse_i,
   input logic              wide_q,
   input logic              armed_o,
   input logic              done_o,
   input logic [HALF_W-1:0] lo_o,
   input logic [HALF_W-1:0] hi_o
);
   AST_LO_STEP: assert property (@(posedge clk) disable iff (rst)
      (armed_o && !done_o && pulse_i && !load_i && !arm_i &&
       !(lo_o == '0 && (!wide_q || hi_o == '0)))
      |=> lo_o == HALF_W'($past(lo_o) - 1'b1)); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!pulse_i && !load_i) |=> ($stable(lo_o) && $stable(hi_o))); // R8

   AST_NOT_ARMED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!armed_o && !load_i) |=> ($stable(lo_o) && $stable(hi_o))); // R8

   AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (done_o && !load_i) |=> ($stable(lo_o) && $stable(hi_o))); // R7

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      (done_o && !load_i && !arm_i) |=> done_o); // R7

   AST_NARROW_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!wide_q && !load_i) |=> $stable(hi_o)); // R6

   AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> (lo_o == '0 && (!wide_q || hi_o == '0))); // R5

   AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (!done_o && !armed_o)); // R9
endmodule

bind sample_cascade_counter sample_cascade_counter_chk #(.HALF_W(HALF_W)) chk_i (
   .clk     (clk),
   .rst     (rst),
   .load_i  (load_i),
   .arm_i   (arm_i),
   .pulse_i (pulse_i),
   .wide_q  (wide_q),
   .armed_o (armed_o),
   .done_o  (done_o),
   .lo_o    (lo_o),
   .hi_o    (hi_o)
);

// File: tb/sample_cascade_counter_tb_top.sv
module sample_cascade_counter_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_i = 1'b0;
   logic [31:0] count_i = '0;
   logic        wide_i = 1'b0;
   logic        arm_i = 1'b0;
   logic        pulse_i = 1'b0;
   logic        armed_o;
   logic        done_o;
   logic [15:0] lo_o;
   logic [15:0] hi_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sample_cascade_counter #(.HALF_W(16), .CASCADE_EN(1'b1)) dut_i (
      .clk(clk), .rst(rst), .load_i(load_i), .count_i(count_i), .wide_i(wide_i),
      .arm_i(arm_i), .pulse_i(pulse_i), .armed_o(armed_o), .done_o(done_o),
      .lo_o(lo_o), .hi_o(hi_o)
   );

   function automatic logic [15:0] exp_lo(input logic [31:0] n);
      return n[15:0] - 16'd1;
   endfunction

   function automatic logic [15:0] exp_hi(input logic [31:0] n);
      return (n[15:0] > 16'd1) ? n[31:16] + 16'd1 : n[31:16];
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [31:0] n, input bit w);
      @(negedge clk);
      load_i = 1'b1; count_i = n; wide_i = w;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic do_arm();
      @(negedge clk);
      arm_i = 1'b1;
      @(negedge clk);
      arm_i = 1'b0;
   endtask

   task automatic pulses(input int n, input bit gaps);
      if (n <= 0) return;
      if (!gaps) begin
         @(negedge clk);
         pulse_i = 1'b1;
         repeat (n) @(negedge clk);
         pulse_i = 1'b0;
      end else begin
         for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pulse_i = 1'b1;
            @(negedge clk);
            pulse_i = 1'b0;
            if ($urandom % 3 == 0) @(negedge clk);
         end
      end
   endtask

   task automatic run_to_done(input logic [31:0] n, input bit w, input string req);
      logic [15:0] hi0;
      int total;
      total = w ? int'(n[31:16]) * 65536 + int'(n[15:0]) : int'(n[15:0]);
      do_load(n, w);
      hi0 = hi_o;
      do_arm();
      pulses(total - 1, 1'b1);
      chk({req, " done low before last pulse"}, done_o, 0);
      if (!w) chk("R6 high half held in narrow mode", hi_o, exp_hi(n));
      pulses(1, 1'b0);
      chk({req, " done after last pulse"}, done_o, 1);
      if (!w) chk("R6 high half still at preset", hi_o, hi0);
   endtask

   initial begin
      logic [31:0] n;
      logic [15:0] lo_snap;
      void'($urandom(32'h5A17));

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 reset done", done_o, 0);
      chk("R10 reset armed", armed_o, 0);
      chk("R10 reset lo", lo_o, 0);
      chk("R10 reset hi", hi_o, 0);

      do_arm();
      chk("R8 arm before load ignored", armed_o, 0);
      pulses(3, 1'b0);
      chk("R8 pulses unarmed ignored", lo_o, 0);

      foreach (n_dir[i]) begin
         do_load(n_dir[i], 1'b1);
         chk("R1 low preset", lo_o, exp_lo(n_dir[i]));
         chk("R2 high preset", hi_o, exp_hi(n_dir[i]));
      end
      for (int i = 0; i < 20; i++) begin
         n = $urandom;
         do_load(n, 1'b1);
         chk("R1 low preset random", lo_o, exp_lo(n));
         chk("R2 high preset random", hi_o, exp_hi(n));
      end

      do_load(32'h0002_0003, 1'b1);
      pulses(2, 1'b0);
      chk("R8 pulses before arm ignored", lo_o, 16'h0002);
      do_arm();
      chk("R8 armed after load", armed_o, 1);
      pulses(2, 1'b1);
      chk("R3 low decremented", lo_o, 16'h0000);
      chk("R4 high dropped when low reached zero", hi_o, 16'h0002);
      pulses(1, 1'b0);
      chk("R3 low wraps", lo_o, 16'hFFFF);
      chk("R4 high unchanged on wrap", hi_o, 16'h0002);

      for (int i = 0; i < 5; i++) begin
         n = {$urandom % 65536, 16'(1 + $urandom % 300)};
         run_to_done(n[31:0], 1'b0, "R6");
         lo_snap = lo_o;
         pulses(3, 1'b1);
         chk("R7 done sticky", done_o, 1);
         chk("R7 low frozen after done", lo_o, lo_snap);
      end
      for (int i = 0; i < 5; i++) begin
         n = {16'h0000, 16'(2 + $urandom % 300)};
         run_to_done(n, 1'b1, "R5");
      end
      run_to_done(32'h0000_0001, 1'b1, "R5 count one");
      run_to_done(32'h0000_0002, 1'b1, "R5 count two");

      do_arm();
      chk("R7 arm clears done", done_o, 0);
      chk("R7 arm sets armed", armed_o, 1);

      do_load(32'h0000_0100, 1'b1);
      do_arm();
      pulses(5, 1'b0);
      @(negedge clk);
      load_i = 1'b1; arm_i = 1'b1; pulse_i = 1'b1; count_i = 32'h0003_0010; wide_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0; arm_i = 1'b0; pulse_i = 1'b0;
      chk("R9 load beats arm", armed_o, 0);
      chk("R9 load beats pulse", lo_o, 16'h000F);
      chk("R9 load clears done", done_o, 0);

      do_arm();
      pulses(4, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R10 reset mid count lo", lo_o, 0);
      chk("R10 reset mid count armed", armed_o, 0);
      do_arm();
      chk("R10 reset forgets load", armed_o, 0);

      do_load(32'h0001_0001, 1'b1);
      do_arm();
      pulses(65536, 1'b0);
      chk("R5 long run low at zero", lo_o, 0);
      chk("R5 long run high at zero", hi_o, 0);
      chk("R5 long run not yet done", done_o, 0);
      pulses(1, 1'b0);
      chk("R5 long run done", done_o, 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   logic [31:0] n_dir [6] = '{32'h0005_0000, 32'h0005_0001, 32'h0005_0002,
                              32'h1234_FFFF, 32'hFFFF_0007, 32'h0000_0000};

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule